// File: doc/BRIEF.md
# Two-Event Classification Tracker

This block is the digital sequencing core of a powered-device interface controller. Analog comparators outside the block reduce the input supply voltage to a window code. On each clock the block samples that code and drives three things. The first is the enable for the detection-signature switch. The second is the enable for the classification-current regulator. The third is an active-low indication that a high-power source is available.

The block follows the window sequence the power source steps through. Its main job is to recognise the pattern of two classification events separated by a mark event. On the first drop from classification into the mark window it presents a deliberately invalid signature. A valid two-event pattern latches a high-power result when the input rises past the upper classification threshold. That result, and any broken-path memory, survive every later window change. Only a drop below the mark-reset level clears them.

Three flags gate the outputs. An adapter-present flag can stand in for a high-power source. A detection-disable flag and a thermal-shutdown flag suppress the classification regulator. An inrush-active flag from the hotswap logic holds the indication off.

Top module: `pd_class_tracker`

## Requirements
- R1: Window codes are 0 below mark reset, 1 detection, 2 mark, 3 classification, 4 above the upper classification threshold, 5 operating. One clock after a code is sampled, the outputs reflect it. `det_en` is 1 only while the window is detection (1) and no invalid signature is latched.
- R2: `cls_en` is 1 only while the window is classification (3) and `aux_in`, `den_dis` and `otsd` are all 0.
- R3: A change from window 3 to window 2 latches the invalid signature. While it is latched, `det_spoil` is 1 in windows 1 and 2, and `det_en` stays 0. The latch holds until the window becomes 0.
- R4: Starting from idle, the window changes classification, then mark, then classification, then above-threshold (3, 2, 3, 4). This sequence latches the high-power result.
- R5: The latched high-power result persists through every window change except one to window 0. Window 0 clears it, clears the invalid-signature latch and returns tracking to idle.
- R6: Any other window change while the sequence is being tracked breaks the path. This includes a rise from idle into window 4 or 5. After a break, no high-power result latches until window 0 has been seen.
- R7: `hp_n` is 0 exactly when (high-power latched OR `aux_in`) AND `inrush` is 0 AND `otsd` is 0.
- R8: Codes 6 and 7 are illegal and cause no change: the sampled window and the tracking state are held.
- R9: While `rst` is 1, the outputs are inactive (`det_en`, `det_spoil`, `cls_en` 0, `hp_n` 1). The clock edge with `rst` at 1 puts tracking in idle with the window at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| win_code | input | 3 | Voltage window code from the comparators |
| aux_in | input | 1 | Auxiliary adapter present |
| den_dis | input | 1 | Detection-disable condition active |
| otsd | input | 1 | Thermal shutdown active |
| inrush | input | 1 | Hotswap current limit is in inrush mode |
| det_en | output | 1 | Detection-signature switch enable |
| det_spoil | output | 1 | Invalid low-resistance signature enable |
| cls_en | output | 1 | Classification-current regulator enable |
| hp_n | output | 1 | High-power source indication, active low |

## Verification
Three kinds of sequence are tried. A clean classification, mark, classification, rise sequence must set the indication. A single-event rise, which is how a low-power source behaves, must leave it clear. An out-of-order sequence that still contains a mark must also leave it clear, which separates tracking of the path from mere spotting of a mark. A mark reset followed by a clean sequence shows that a broken path recovers only through window 0. Illegal codes inserted between legal windows check that they do not count as transitions. Toggling the adapter, disable, thermal and inrush flags at fixed windows separates the gating terms in the regulator and indication logic.

// File: rtl/pd_trk_pkg.sv
package pd_trk_pkg;
  localparam int WIN_W   = 3;
  localparam int WIN_MAX = 5;

  typedef enum logic [WIN_W-1:0] {
    WIN_BELOW  = 3'd0,
    WIN_DETECT = 3'd1,
    WIN_MARK   = 3'd2,
    WIN_CLASS  = 3'd3,
    WIN_ABOVE  = 3'd4,
    WIN_OPER   = 3'd5
  } win_e;

  typedef enum logic [2:0] {
    TRK_IDLE,
    TRK_CLS1,
    TRK_MARK1,
    TRK_CLS2,
    TRK_HIPWR,
    TRK_BROKEN
  } trk_e;

  function automatic logic code_legal(input logic [WIN_W-1:0] c);
    return (int'(c) <= WIN_MAX);
  endfunction
endpackage

// File: rtl/pd_win_sampler.sv
module pd_win_sampler
  import pd_trk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [WIN_W-1:0] code_in,
  output win_e             win_q,
  output win_e             win_nxt
);
  // illegal codes keep the previous window
  always_comb begin
    if (code_legal(code_in)) win_nxt = win_e'(code_in);
    else                     win_nxt = win_q;
  end

  always_ff @(posedge clk) begin
    if (rst) win_q <= WIN_BELOW;
    else     win_q <= win_nxt;
  end
endmodule

// File: rtl/pd_seq_tracker.sv
module pd_seq_tracker
  import pd_trk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  win_e win_q,
  input  win_e win_nxt,
  output logic hp_lat,
  output logic spoil_lat
);
  trk_e st, st_nxt;
  logic spoil_nxt;

  always_comb begin
    st_nxt    = st;
    spoil_nxt = spoil_lat;
    if (win_nxt != win_q) begin
      if (win_nxt == WIN_BELOW) begin
        st_nxt    = TRK_IDLE;
        spoil_nxt = 1'b0;
      end else begin
        if (win_q == WIN_CLASS && win_nxt == WIN_MARK) spoil_nxt = 1'b1;
        case (st)
          TRK_IDLE: begin
            if (win_nxt == WIN_CLASS) st_nxt = TRK_CLS1;
            else if (win_nxt == WIN_ABOVE || win_nxt == WIN_OPER) st_nxt = TRK_BROKEN;
          end
          TRK_CLS1:  st_nxt = (win_nxt == WIN_MARK)  ? TRK_MARK1 : TRK_BROKEN;
          TRK_MARK1: st_nxt = (win_nxt == WIN_CLASS) ? TRK_CLS2  : TRK_BROKEN;
          TRK_CLS2:  st_nxt = (win_nxt == WIN_ABOVE) ? TRK_HIPWR : TRK_BROKEN;
          default:   st_nxt = st;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= TRK_IDLE;
      spoil_lat <= 1'b0;
    end else begin
      st        <= st_nxt;
      spoil_lat <= spoil_nxt;
    end
  end

  assign hp_lat = (st == TRK_HIPWR);
endmodule

// File: rtl/pd_out_drive.sv
module pd_out_drive
  import pd_trk_pkg::*;
(
  input  logic rst,
  input  win_e win_q,
  input  logic hp_lat,
  input  logic spoil_lat,
  input  logic aux_in,
  input  logic den_dis,
  input  logic otsd,
  input  logic inrush,
  output logic det_en,
  output logic det_spoil,
  output logic cls_en,
  output logic hp_n
);
  logic in_low_win;
  logic hp_src;

  assign in_low_win = (win_q == WIN_DETECT) || (win_q == WIN_MARK);
  assign hp_src     = (hp_lat || aux_in) && !inrush && !otsd;

  always_comb begin
    det_en    = !rst && (win_q == WIN_DETECT) && !spoil_lat;
    det_spoil = !rst && in_low_win && spoil_lat;
    cls_en    = !rst && (win_q == WIN_CLASS) && !aux_in && !den_dis && !otsd;
    hp_n      = rst || !hp_src;
  end
endmodule

// File: rtl/pd_class_tracker.sv
module pd_class_tracker
  import pd_trk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [WIN_W-1:0] win_code,
  input  logic             aux_in,
  input  logic             den_dis,
  input  logic             otsd,
  input  logic             inrush,
  output logic             det_en,
  output logic             det_spoil,
  output logic             cls_en,
  output logic             hp_n
);
  win_e win_q, win_nxt;
  logic hp_lat, spoil_lat;

  pd_win_sampler u_smp (
    .clk(clk), .rst(rst), .code_in(win_code),
    .win_q(win_q), .win_nxt(win_nxt)
  );

  pd_seq_tracker u_trk (
    .clk(clk), .rst(rst), .win_q(win_q), .win_nxt(win_nxt),
    .hp_lat(hp_lat), .spoil_lat(spoil_lat)
  );

  pd_out_drive u_out (
    .rst(rst), .win_q(win_q), .hp_lat(hp_lat), .spoil_lat(spoil_lat),
    .aux_in(aux_in), .den_dis(den_dis), .otsd(otsd), .inrush(inrush),
    .det_en(det_en), .det_spoil(det_spoil), .cls_en(cls_en), .hp_n(hp_n)
  );
endmodule

// File: rtl/pd_class_tracker_chk.sv
module pd_class_tracker_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] win_code,
  input logic [2:0] win_q,
  input logic       aux_in,
  input logic       den_dis,
  input logic       otsd,
  input logic       inrush,
  input logic       det_en,
  input logic       det_spoil,
  input logic       cls_en,
  input logic       hp_n
);
  logic legal;
  assign legal = (win_code <= 3'd5);

  // R1
  det_window_chk: assert property (@(posedge clk) disable iff (rst)
    (legal && win_code == 3'd1) |=> (det_en ^ det_spoil));

  // R2
  cls_gate_chk: assert property (@(posedge clk) disable iff (rst)
    cls_en |-> !(aux_in || den_dis || otsd));

  // R3
  spoil_excl_chk: assert property (@(posedge clk) disable iff (rst)
    det_spoil |-> !det_en);

  // R5
  mark_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (legal && win_code == 3'd0) |=> (!det_spoil && (hp_n || aux_in)));

  // R7
  ind_release_chk: assert property (@(posedge clk) disable iff (rst)
    (inrush || otsd) |-> hp_n);

  // R8
  illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !legal |=> $stable(win_q));
endmodule

bind pd_class_tracker pd_class_tracker_chk u_chk (
  .clk(clk), .rst(rst), .win_code(win_code), .win_q(win_q),
  .aux_in(aux_in), .den_dis(den_dis), .otsd(otsd), .inrush(inrush),
  .det_en(det_en), .det_spoil(det_spoil), .cls_en(cls_en), .hp_n(hp_n)
);

// File: tb/pd_class_tracker_bench.sv
module pd_class_tracker_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] win_code = 3'd0;
  logic       aux_in = 1'b0, den_dis = 1'b0, otsd = 1'b0, inrush = 1'b0;
  logic       det_en, det_spoil, cls_en, hp_n;
  int         total = 0, fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  pd_class_tracker u_pd_class_tracker (
    .clk(clk), .rst(rst), .win_code(win_code), .aux_in(aux_in),
    .den_dis(den_dis), .otsd(otsd), .inrush(inrush),
    .det_en(det_en), .det_spoil(det_spoil), .cls_en(cls_en), .hp_n(hp_n)
  );

  // {code, aux den otsd inrush, exp det_en det_spoil cls_en hp_n}
  localparam int NV = 33;
  localparam logic [10:0] VEC [0:NV-1] = '{
    {3'd1, 4'b0000, 4'b1001},  // detect
    {3'd3, 4'b0000, 4'b0011},  // first class
    {3'd3, 4'b1000, 4'b0000},  // R2 aux gates cls, R7 aux sets indication
    {3'd3, 4'b0100, 4'b0001},  // R2 detection-disable
    {3'd2, 4'b0000, 4'b0101},  // R3 first mark
    {3'd3, 4'b0010, 4'b0001},  // R2 thermal, second class
    {3'd3, 4'b0000, 4'b0011},
    {3'd4, 4'b0000, 4'b0000},  // R4 latch
    {3'd5, 4'b0001, 4'b0001},  // R7 inrush releases
    {3'd5, 4'b0000, 4'b0000},
    {3'd5, 4'b0010, 4'b0001},  // R7 thermal releases
    {3'd2, 4'b0000, 4'b0100},  // R5 latch survives
    {3'd1, 4'b0000, 4'b0100},  // R3 spoil held in detect
    {3'd0, 4'b0000, 4'b0001},  // R5 mark reset clears
    {3'd1, 4'b0000, 4'b1001},
    {3'd3, 4'b0000, 4'b0011},
    {3'd4, 4'b0000, 4'b0001},  // R6 single event
    {3'd5, 4'b0000, 4'b0001},
    {3'd6, 4'b0000, 4'b0001},  // R8 illegal
    {3'd3, 4'b0000, 4'b0011},
    {3'd2, 4'b0000, 4'b0101},
    {3'd3, 4'b0000, 4'b0011},
    {3'd4, 4'b0000, 4'b0001},  // R6 still broken
    {3'd0, 4'b0000, 4'b0001},
    {3'd1, 4'b0000, 4'b1001},
    {3'd7, 4'b0000, 4'b1001},  // R8 illegal holds detect
    {3'd3, 4'b0000, 4'b0011},
    {3'd2, 4'b0000, 4'b0101},
    {3'd3, 4'b0000, 4'b0011},
    {3'd4, 4'b0000, 4'b0000},  // R6 recovered after reset
    {3'd1, 4'b0000, 4'b0100},
    {3'd5, 4'b1001, 4'b0001},  // R7 inrush beats aux
    {3'd5, 4'b1000, 4'b0000}
  };

  task automatic chk(input string tag, input int idx, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s step %0d act=%0b exp=%0b", tag, idx, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic [3:0] fl);
    @(negedge clk);
    win_code = c;
    {aux_in, den_dis, otsd, inrush} = fl;
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  endtask

  initial begin
    // R9 reset with adapter present
    aux_in = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    chk("R9 det_en", -1, det_en, 1'b0);
    chk("R9 det_spoil", -1, det_spoil, 1'b0);
    chk("R9 cls_en", -1, cls_en, 1'b0);
    chk("R9 hp_n", -1, hp_n, 1'b1);
    @(negedge clk);
    rst = 1'b0;
    aux_in = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][10:8], VEC[i][7:4]);
      chk("R1 det_en", i, det_en, VEC[i][3]);
      chk("R3 det_spoil", i, det_spoil, VEC[i][2]);
      chk("R2 cls_en", i, cls_en, VEC[i][1]);
      chk("R7 hp_n", i, hp_n, VEC[i][0]);
    end

    // R9 reset mid high-power clears latch
    step(3'd0, 4'b0000);
    step(3'd3, 4'b0000);
    step(3'd2, 4'b0000);
    step(3'd3, 4'b0000);
    step(3'd4, 4'b0000);
    chk("R4 hp_n", 100, hp_n, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    #1;
    chk("R9 hp_n during reset", 101, hp_n, 1'b1);
    @(posedge clk);
    #2;
    @(negedge clk);
    rst = 1'b0;
    step(3'd4, 4'b0000);
    chk("R9 hp_n after reset", 102, hp_n, 1'b1);
    step(3'd2, 4'b0000);
    chk("R9 no spoil after reset", 103, det_spoil, 1'b0);

    // R6 class then straight to detect breaks path
    step(3'd0, 4'b0000);
    step(3'd3, 4'b0000);
    step(3'd1, 4'b0000);
    step(3'd3, 4'b0000);
    step(3'd2, 4'b0000);
    step(3'd3, 4'b0000);
    step(3'd4, 4'b0000);
    chk("R6 hp_n broken", 104, hp_n, 1'b1);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule